// File: doc/BRIEF.md
# Permuting Message Switch with Per-Destination Queues

This block moves soft values from N parallel producers to N consumers in any order a decoding block needs. Each cycle, every producer may offer one message. A message is a payload plus the index of the consumer it must reach. The switch steers each accepted message into a queue that belongs to its destination. Each queue drains to its consumer port at most once per cycle, under a valid/ready handshake.

The destination pattern may change from one block to the next, so the switch does not rely on a conflict-free schedule. When several producers aim at the same consumer in one cycle, that consumer's queue takes as many of them as it has free slots for. A rotating priority picks which producers go first. The producers that lose are held by a low ready and keep their message until a later cycle. Producers aimed at other consumers are not affected and carry on streaming.

Top module: `icx_switch`

## Requirements
- R1: While reset is held, and in the first cycle after it, all `dst_valid` bits and all `src_ready` bits are low.
- R2: A message accepted on source s, with destination field `src_dest[s*IDW +: IDW]` = d and payload `src_data[s*W +: W]`, later appears on `dst_data[d*W +: W]` with the same payload.
- R3: `src_ready[s]` is high only while `src_valid[s]` is high. When all valid sources target different destinations whose queues have room, every one of them is ready in that same cycle.
- R4: If a queue has at least N free slots, up to N sources targeting it in one cycle are all accepted together, and the queue then delivers them one per cycle.
- R5: Messages written to one queue in the same cycle are delivered in the order of the rotating priority. After reset, that priority starts at source 0, so simultaneous arrivals come out in ascending source index.
- R6: When more sources target a queue than it has free slots, only as many sources as there are free slots are ready, taken in priority order. The held sources keep their message, and it is accepted later without loss.
- R7: The first source denied at a queue becomes that queue's highest-priority source in the next cycle.
- R8: Messages from one source to one destination leave in the order they were accepted.
- R9: A queue never holds more than DEPTH messages. While `dst_valid[d]` is high and `dst_ready[d]` is low, `dst_valid[d]` and `dst_data[d*W +: W]` stay unchanged.
- R10: An accepted message is visible on its destination port in the cycle after acceptance. Free space is taken at the start of a cycle, so a pop does not make room for a write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | N | One message offered per source |
| src_dest | input | N*IDW | Destination index for each source |
| src_data | input | N*W | Payload for each source |
| src_ready | output | N | Message on this source is taken this cycle |
| dst_valid | output | N | Destination queue is not empty |
| dst_data | output | N*W | Head payload of each destination queue |
| dst_ready | input | N | Consumer takes the head payload |

## Verification
A write collision and a pop can fall in the same cycle on one queue. In that cycle the arbitration must see only the start-of-cycle free space, while the freed slot counts only from the next cycle. The bench fills one queue, leaves held sources waiting, and then raises that consumer's ready while the held sources retry. It checks that ready stays low in the popping cycle. After that, exactly one denied source per cycle is granted, in the rotated order, and the full delivery sequence matches the order of acceptance.

// File: rtl/icx_pkg.sv
package icx_pkg;
  // Source index visited at step k of a rotation that starts at base.
  function automatic int rot_idx(input int base, input int k, input int n);
    return (base + k) % n;
  endfunction
endpackage

// File: rtl/icx_arb.sv
module icx_arb #(
  parameter int N     = 4,
  parameter int DEPTH = 4,
  localparam int IDW  = (N > 1) ? $clog2(N) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic [CW-1:0]  space,
  output logic [N-1:0]   grant,
  output logic [N-1:0]   lane_vld,
  output logic [N*IDW-1:0] lane_src
);
  import icx_pkg::*;

  logic [IDW-1:0] ptr_q, ptr_d;
  logic           deny;

  always_comb begin
    int cnt;
    cnt      = 0;
    grant    = '0;
    lane_vld = '0;
    lane_src = '0;
    deny     = 1'b0;
    ptr_d    = ptr_q;
    for (int k = 0; k < N; k++) begin
      int s;
      s = rot_idx(int'(ptr_q), k, N);
      if (req[s]) begin
        if (cnt < int'(space)) begin
          grant[s]                  = 1'b1;
          lane_vld[cnt]             = 1'b1;
          lane_src[cnt*IDW +: IDW]  = IDW'(s);
          cnt++;
        end else if (!deny) begin
          deny  = 1'b1;
          ptr_d = IDW'(s);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (deny) ptr_q <= ptr_d;
  end

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);                                   // R3
  AST_GRANT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= int'(space));                       // R6
  AST_DENY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (deny && $countones(grant) < N) |=> ptr_q == $past(ptr_d)); // R7
endmodule

// File: rtl/icx_ofifo.sv
module icx_ofifo #(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   lane_vld,
  input  logic [N*W-1:0] lane_data,
  input  logic           rd_rdy,
  output logic           rd_vld,
  output logic [W-1:0]   rd_data,
  output logic [CW-1:0]  space
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d, nwr;
  logic          pop, upd;

  assign rd_vld  = (cnt_q != '0);
  assign rd_data = mem[rp_q];
  assign space   = CW'(DEPTH) - cnt_q;
  assign pop     = rd_vld & rd_rdy;

  always_comb begin
    nwr = '0;
    for (int k = 0; k < N; k++) nwr = nwr + CW'(lane_vld[k]);
    wp_d  = wp_q + AW'(nwr);
    rp_d  = rp_q + AW'(pop);
    cnt_d = cnt_q + nwr - CW'(pop);
    upd   = pop || (nwr != '0);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++)
      if (lane_vld[k]) mem[wp_q + AW'(k)] <= lane_data[k*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));                                    // R9
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && !rd_rdy) |=> (rd_vld && $stable(rd_data)));   // R9
  AST_FILL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld != '0) |=> rd_vld);                            // R10
endmodule

// File: rtl/icx_switch.sv
module icx_switch #(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int IDW  = (N > 1) ? $clog2(N) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     src_valid,
  input  logic [N*IDW-1:0] src_dest,
  input  logic [N*W-1:0]   src_data,
  output logic [N-1:0]     src_ready,
  output logic [N-1:0]     dst_valid,
  output logic [N*W-1:0]   dst_data,
  input  logic [N-1:0]     dst_ready
);
  logic [N-1:0] gnt_m [N];

  for (genvar d = 0; d < N; d++) begin : g_dst
    logic [N-1:0]     req;
    logic [N-1:0]     lane_vld;
    logic [N*IDW-1:0] lane_src;
    logic [N*W-1:0]   lane_data;
    logic [CW-1:0]    space;

    always_comb begin
      for (int s = 0; s < N; s++)
        req[s] = src_valid[s] && (src_dest[s*IDW +: IDW] == IDW'(d));
      for (int k = 0; k < N; k++)
        lane_data[k*W +: W] = src_data[int'(lane_src[k*IDW +: IDW])*W +: W];
    end

    icx_arb #(.N(N), .DEPTH(DEPTH)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req), .space(space),
      .grant(gnt_m[d]), .lane_vld(lane_vld), .lane_src(lane_src)
    );

    icx_ofifo #(.N(N), .W(W), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .lane_vld(lane_vld), .lane_data(lane_data),
      .rd_rdy(dst_ready[d]), .rd_vld(dst_valid[d]),
      .rd_data(dst_data[d*W +: W]), .space(space)
    );
  end

  always_comb begin
    src_ready = '0;
    for (int d = 0; d < N; d++) src_ready = src_ready | gnt_m[d];
  end

  AST_READY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready & ~src_valid) == '0);                         // R3
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_m[0] & gnt_m[N-1]) && ((gnt_m[0] & gnt_m[N-1]) == '0)); // R2
endmodule

// File: tb/icx_switch_tb.sv
module icx_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, W = 8, IDW = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N-1:0]     src_valid, src_ready, dst_valid, dst_ready;
  logic [N*IDW-1:0] src_dest;
  logic [N*W-1:0]   src_data, dst_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] plog [16];
  int nlog = 0;

  // {valid[15:12], dest src3..src0 [11:4], expected ready [3:0]}
  localparam logic [15:0] VEC [4] = '{
    {4'hF, 8'b11_10_01_00, 4'hF},
    {4'hF, 8'b00_01_10_11, 4'hF},
    {4'hF, 8'b10_11_00_01, 4'hF},
    {4'h5, 8'b00_00_00_10, 4'h5}
  };

  icx_switch #(.N(N), .W(W), .DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_dest(src_dest),
    .src_data(src_data), .src_ready(src_ready), .dst_valid(dst_valid),
    .dst_data(dst_data), .dst_ready(dst_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && dst_valid[1] && dst_ready[1] && nlog < 16) begin
      plog[nlog] = dst_data[15:8];
      nlog++;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0]   ev;
    logic [N*W-1:0] ed;
    logic [7:0]     exp_log [7];
    rst_n = 1'b0; src_valid = '0; src_dest = '0; src_data = '0; dst_ready = '0;
    repeat (3) @(negedge clk);
    chk(dst_valid == '0 && src_ready == '0, "R1", int'(dst_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(dst_valid == '0, "R1", int'(dst_valid), 0);

    // Table of permutations, queues empty at each row.
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      src_valid = VEC[r][15:12];
      src_dest  = VEC[r][11:4];
      for (int s = 0; s < N; s++) src_data[s*W +: W] = 8'(r*16 + s);
      dst_ready = '1;
      ev = '0; ed = '0;
      for (int s = 0; s < N; s++)
        if (src_valid[s]) begin
          ev[src_dest[s*IDW +: IDW]] = 1'b1;
          ed[int'(src_dest[s*IDW +: IDW])*W +: W] = 8'(r*16 + s);
        end
      #1 chk(src_ready == VEC[r][3:0], "R3", int'(src_ready), int'(VEC[r][3:0]));
      @(negedge clk);
      src_valid = '0;
      #1 chk(dst_valid == ev, "R10", int'(dst_valid), int'(ev));
      for (int d = 0; d < N; d++)
        if (ev[d]) chk(dst_data[d*W +: W] == ed[d*W +: W], "R2",
                       int'(dst_data[d*W +: W]), int'(ed[d*W +: W]));
      @(negedge clk); #1;
      chk(dst_valid == '0, "R2", int'(dst_valid), 0);
    end

    // All four sources into destination 0 in one cycle.
    @(negedge clk);
    dst_ready = 4'b1110; src_valid = '1; src_dest = '0;
    for (int s = 0; s < N; s++) src_data[s*W +: W] = 8'h40 + 8'(s);
    #1 chk(src_ready == 4'hF, "R4", int'(src_ready), 15);
    @(negedge clk);
    src_valid = '0; dst_ready = '1;
    for (int k = 0; k < N; k++) begin
      if (k > 0) @(negedge clk);
      #1 chk(dst_valid[0] && dst_data[7:0] == 8'h40 + 8'(k), "R5",
             int'(dst_data[7:0]), 32'h40 + k);
    end
    @(negedge clk); #1;
    chk(dst_valid[0] == 1'b0, "R4", int'(dst_valid[0]), 0);

    // Backpressure and rotation on destination 1.
    nlog = 0;
    @(negedge clk);
    dst_ready = 4'b1101; src_valid = 4'b0011; src_dest = 8'b01_01_01_01;
    src_data = {8'h13, 8'h12, 8'h11, 8'h10};
    #1 chk(src_ready == 4'b0011, "R3", int'(src_ready), 3);
    @(negedge clk);
    src_valid = 4'hF; src_data = {8'h23, 8'h22, 8'h21, 8'h20};
    #1 chk(src_ready == 4'b0011, "R6", int'(src_ready), 3);
    @(negedge clk);
    src_valid = 4'b1100;
    #1 chk(src_ready == 4'b0000, "R6", int'(src_ready), 0);
    chk(dst_valid[1] && dst_data[15:8] == 8'h10, "R9", int'(dst_data[15:8]), 32'h10);
    @(negedge clk);
    dst_ready = '1;
    #1 chk(src_ready == 4'b0000, "R10", int'(src_ready), 0);
    chk(dst_data[15:8] == 8'h10, "R9", int'(dst_data[15:8]), 32'h10);
    @(negedge clk);
    src_valid = 4'b1101; src_data[7:0] = 8'h30;
    #1 chk(src_ready == 4'b0100, "R7", int'(src_ready), 4);
    @(negedge clk);
    src_valid = 4'b1001;
    #1 chk(src_ready == 4'b1000, "R7", int'(src_ready), 8);
    @(negedge clk);
    src_valid = 4'b0001;
    #1 chk(src_ready == 4'b0001, "R6", int'(src_ready), 1);
    @(negedge clk);
    src_valid = '0;
    repeat (8) @(negedge clk);
    #3;
    exp_log = '{8'h10, 8'h11, 8'h20, 8'h21, 8'h22, 8'h23, 8'h30};
    chk(nlog == 7, "R6", nlog, 7);
    for (int i = 0; i < 7; i++)
      if (i < nlog) chk(plog[i] == exp_log[i], "R8", int'(plog[i]), int'(exp_log[i]));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule